// File: doc/BRIEF.md
# Scan Result Buffer with Wrapping Byte Readback

This block sits between a multichannel converter's scan controller and a serial-bus slave. During a scan the controller delivers one 10-bit result per converted channel, and the block stores them in arrival order. When the controller marks the last result, the block emits a one-cycle completion pulse. From then on, a byte-oriented reader can pull the stored results out, two bytes per result, for as long as it likes. When the reader passes the final stored byte, it continues from the first result again.

A fresh scan-start throws away everything from the previous scan and blocks reads until the new scan completes. One channel number is shared with the reference pin. When the reference-select input is high, any result that arrives tagged with that channel is dropped, so the stored count is the number of channels actually kept. Reading never starts a conversion. Only another scan-start refreshes the contents.

Top module: `sbuf_top`

## Requirements
- R1: After reset, `scan_done` and `rd_valid` are 0, and a read request before any scan has completed returns byte 0x00 with `rd_underrun` = 1.
- R2: Results are returned in the order they were written during the scan (first written, first read).
- R3: Each result is returned as two bytes. The first byte is {6'b000000, result[9:8]} and the second byte is result[7:0].
- R4: A read that follows the second byte of the last stored result returns the first byte of the first stored result. Readback wraps indefinitely over the current scan only.
- R5: A `scan_start` pulse discards all earlier results and resets the read position. Until the new scan completes, reads return 0x00 with `rd_underrun` = 1.
- R6: While `ref_sel` = 1, a write whose `wr_chan` equals parameter REF_CHAN (default 11) stores nothing. While `ref_sel` = 0, that channel is stored like any other.
- R7: `scan_done` is high for exactly one cycle: the cycle after the clock edge that accepts a write with `wr_last` = 1.
- R8: Each `rd_req` sampled high produces exactly one `rd_valid` pulse in the following cycle, and `rd_valid` never appears without a request.
- R9: At most DEPTH (default 12) results are kept per scan. Writes beyond that are dropped, and readback wraps after the DEPTH-th result.
- R10: Read requests never cause `scan_done` to assert and never change the stored results.
- R11: If a scan completes with no stored result (every write excluded), each read returns 0x00 with `rd_underrun` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Pulse: begin a new scan, discarding earlier results |
| ref_sel | input | 1 | High: the shared reference channel is excluded from storage |
| wr_valid | input | 1 | A result is presented on wr_chan/wr_data |
| wr_chan | input | CH_W (4) | Channel number of the presented result |
| wr_data | input | 10 | Converted result |
| wr_last | input | 1 | Marks the final write of the scan |
| scan_done | output | 1 | One-cycle pulse after the final write is accepted |
| rd_req | input | 1 | Request the next byte |
| rd_valid | output | 1 | A byte is presented on rd_byte |
| rd_byte | output | 8 | Returned byte |
| rd_underrun | output | 1 | With rd_valid: no result was available, and rd_byte is 0x00 |

## Verification
The hardest situation to reach is a wrap at a point other than the full buffer end. This requires a scan where exclusion or truncation has changed the stored count. The stimulus therefore runs one full scan, one scan with the reference channel excluded (eleven results), and one scan of fourteen writes (truncated to twelve). After each scan it reads several bytes past the end. A final scan consisting only of the excluded channel produces an empty but completed buffer, which exercises the underrun path after a scan has finished rather than only before the first scan.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int RES_W  = 10;
    localparam int BYTE_W = 8;

    // Byte half of the current result that the next read returns.
    typedef enum logic {
        HALF_HI = 1'b0,
        HALF_LO = 1'b1
    } half_e;

    function automatic logic [BYTE_W-1:0] upper_byte(input logic [RES_W-1:0] r);
        return {{(2*BYTE_W-RES_W){1'b0}}, r[RES_W-1:BYTE_W]};
    endfunction

    function automatic logic [BYTE_W-1:0] lower_byte(input logic [RES_W-1:0] r);
        return r[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/sbuf_excl.sv
module sbuf_excl #(
    parameter int CH_W     = 4,
    parameter int REF_CHAN = 11
) (
    input  logic            ref_sel,
    input  logic [CH_W-1:0] wr_chan,
    output logic            keep
);
    localparam logic [CH_W-1:0] RefCode = CH_W'(REF_CHAN);

    always_comb begin
        keep = 1'b1;
        if (ref_sel && (wr_chan == RefCode)) begin
            keep = 1'b0;
        end
    end
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
    parameter int DEPTH = 12,
    parameter int W     = 10,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (we && (waddr == AW'(gi))) begin
                mem_q[gi] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == AW'(i)) begin
                rdata = mem_q[i];
            end
        end
    end
endmodule

// File: rtl/sbuf_writer.sv
module sbuf_writer #(
    parameter int DEPTH = 12,
    parameter int AW    = 4,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_start,
    input  logic          wr_valid,
    input  logic          wr_last,
    input  logic          keep,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [CW-1:0] count,
    output logic          ready,
    output logic          done
);
    localparam logic [CW-1:0] Full = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          active;
        logic          ready;
        logic          done;
    } wst_t;

    wst_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        we       = 1'b0;
        if (scan_start) begin
            w_d.count  = '0;
            w_d.active = 1'b1;
            w_d.ready  = 1'b0;
        end else if (w_q.active && wr_valid) begin
            if (keep && (w_q.count < Full)) begin
                we        = 1'b1;
                w_d.count = w_q.count + 1'b1;
            end
            if (wr_last) begin
                w_d.active = 1'b0;
                w_d.ready  = 1'b1;
                w_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign waddr = AW'(w_q.count);
    assign count = w_q.count;
    assign ready = w_q.ready;
    assign done  = w_q.done;
endmodule

// File: rtl/sbuf_reader.sv
module sbuf_reader
    import sbuf_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              rd_req,
    input  logic              ready,
    input  logic [CW-1:0]     count,
    input  logic [RES_W-1:0]  rdata,
    output logic [AW-1:0]     raddr,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_underrun,
    output logic              hi_out
);
    typedef struct packed {
        logic [AW-1:0]     ptr;
        half_e             half;
        logic              vld;
        logic              und;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } rst_t;

    rst_t r_d, r_q;
    logic at_end;

    always_comb begin
        at_end = ((CW'(r_q.ptr) + 1'b1) == count);
    end

    always_comb begin
        r_d      = r_q;
        r_d.vld  = rd_req;
        r_d.und  = 1'b0;
        r_d.hi   = 1'b0;
        r_d.data = '0;
        if (rd_req) begin
            if (!ready || (count == '0)) begin
                r_d.und = 1'b1;
            end else if (r_q.half == HALF_HI) begin
                r_d.data = upper_byte(rdata);
                r_d.hi   = 1'b1;
                r_d.half = HALF_LO;
            end else begin
                r_d.data = lower_byte(rdata);
                r_d.half = HALF_HI;
                r_d.ptr  = at_end ? '0 : r_q.ptr + 1'b1;
            end
        end
        if (restart) begin
            r_d.ptr  = '0;
            r_d.half = HALF_HI;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign raddr       = r_q.ptr;
    assign rd_valid    = r_q.vld;
    assign rd_byte     = r_q.data;
    assign rd_underrun = r_q.und;
    assign hi_out      = r_q.hi;
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
    import sbuf_pkg::*;
#(
    parameter int DEPTH    = 12,
    parameter int CH_W     = 4,
    parameter int REF_CHAN = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_start,
    input  logic                  ref_sel,
    input  logic                  wr_valid,
    input  logic [CH_W-1:0]       wr_chan,
    input  logic [RES_W-1:0]      wr_data,
    input  logic                  wr_last,
    output logic                  scan_done,
    input  logic                  rd_req,
    output logic                  rd_valid,
    output logic [BYTE_W-1:0]     rd_byte,
    output logic                  rd_underrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          keep;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [CW-1:0] count;
    logic          ready;
    logic [RES_W-1:0] rdata;
    logic          hi_out;

    sbuf_excl #(.CH_W(CH_W), .REF_CHAN(REF_CHAN)) u_excl (
        .ref_sel (ref_sel),
        .wr_chan (wr_chan),
        .keep    (keep)
    );

    sbuf_writer #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_start (scan_start),
        .wr_valid   (wr_valid),
        .wr_last    (wr_last),
        .keep       (keep),
        .we         (we),
        .waddr      (waddr),
        .count      (count),
        .ready      (ready),
        .done       (scan_done)
    );

    sbuf_store #(.DEPTH(DEPTH), .W(RES_W), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    sbuf_reader #(.AW(AW), .CW(CW)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (scan_start),
        .rd_req      (rd_req),
        .ready       (ready),
        .count       (count),
        .rdata       (rdata),
        .raddr       (raddr),
        .rd_valid    (rd_valid),
        .rd_byte     (rd_byte),
        .rd_underrun (rd_underrun),
        .hi_out      (hi_out)
    );
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
    parameter int DEPTH = 12,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_start,
    input logic          wr_valid,
    input logic          wr_last,
    input logic          scan_done,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [7:0]    rd_byte,
    input logic          rd_underrun,
    input logic          hi_out,
    input logic [CW-1:0] count
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> $past(wr_valid && wr_last));

    assert_rd_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_no_spurious_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    assert_hi_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && hi_out) |-> (rd_byte[7:2] == 6'b0));

    assert_underrun_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_underrun |-> (rd_valid && (rd_byte == 8'h00)));

    assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> (count == '0));

    assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

bind sbuf_top sbuf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_start  (scan_start),
    .wr_valid    (wr_valid),
    .wr_last     (wr_last),
    .scan_done   (scan_done),
    .rd_req      (rd_req),
    .rd_valid    (rd_valid),
    .rd_byte     (rd_byte),
    .rd_underrun (rd_underrun),
    .hi_out      (hi_out),
    .count       (count)
);

// File: tb/sbuf_top_tb.sv
module sbuf_top_tb;
    localparam int DEPTH = 12;
    localparam int CH_W  = 4;
    localparam int REFC  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_start = 0, ref_sel = 0, wr_valid = 0, wr_last = 0, rd_req = 0;
    logic [CH_W-1:0] wr_chan = '0;
    logic [9:0] wr_data = '0;
    logic scan_done, rd_valid, rd_underrun;
    logic [7:0] rd_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [9:0] mres[$];
    logic [8:0] sb[$];
    bit mready = 0;
    bit mhi = 1;
    int midx = 0;

    always #2 clk = ~clk;

    sbuf_top #(.DEPTH(DEPTH), .CH_W(CH_W), .REF_CHAN(REFC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .ref_sel(ref_sel),
        .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_data(wr_data), .wr_last(wr_last),
        .scan_done(scan_done), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_byte(rd_byte), .rd_underrun(rd_underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design presents them (R2 R3 R4 R8 R11).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8 unrequested byte", {23'd0, rd_underrun, rd_byte}, 0);
            end else begin
                logic [8:0] e;
                e = sb.pop_front();
                chk({rd_underrun, rd_byte} == e,
                    e[8] ? "R11 R1 R5 underrun byte" : "R2 R3 R4 R6 R9 read byte",
                    {23'd0, rd_underrun, rd_byte}, {23'd0, e});
            end
        end
    end

    // Driver: computes the expected byte, queues it, pulses a request.
    task automatic do_read();
        logic [8:0] e;
        if (!mready || mres.size() == 0) begin
            e = {1'b1, 8'h00};
        end else if (mhi) begin
            e = {1'b0, 6'b0, mres[midx][9:8]};
            mhi = 0;
        end else begin
            e = {1'b0, mres[midx][7:0]};
            mhi = 1;
            midx = (midx + 1 == mres.size()) ? 0 : midx + 1;
        end
        sb.push_back(e);
        rd_req = 1;
        @(negedge clk);
        rd_req = 0;
        chk(scan_done == 1'b0, "R10 done during read", scan_done, 0);
    endtask

    task automatic start_scan(input bit sel);
        ref_sel = sel;
        scan_start = 1;
        mres.delete();
        mready = 0; mhi = 1; midx = 0;
        @(negedge clk);
        scan_start = 0;
    endtask

    task automatic write_all(input int n, input bit sel, input int base);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1;
            wr_chan  = CH_W'(i);
            wr_data  = 10'((base + i * 89) & 10'h3FF);
            wr_last  = (i == n - 1);
            if (!(sel && i == REFC) && mres.size() < DEPTH) mres.push_back(wr_data);
            @(negedge clk);
            if (i != n - 1) chk(scan_done == 1'b0, "R7 early done", scan_done, 0);
        end
        wr_valid = 0; wr_last = 0;
        chk(scan_done == 1'b1, "R7 done pulse", scan_done, 1);
        mready = 1;
        @(negedge clk);
        chk(scan_done == 1'b0, "R7 done width", scan_done, 0);
    endtask

    task automatic drain_check();
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R8 missing byte", sb.size(), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(scan_done == 1'b0, "R1 reset done", scan_done, 0);
        chk(rd_valid == 1'b0, "R1 reset valid", rd_valid, 0);
        do_read();
        do_read();
        drain_check();

        // Full scan, no exclusion: R2 R3 R4 R6 (ref channel kept)
        start_scan(1'b0);
        write_all(12, 1'b0, 10'h2C5);
        for (int k = 0; k < 2 * 12 + 6; k++) do_read();
        drain_check();

        // New scan with exclusion; read mid-scan first: R5 R6 R4
        start_scan(1'b1);
        do_read();
        do_read();
        write_all(12, 1'b1, 10'h137);
        chk(mres.size() == 11, "R6 model count", mres.size(), 11);
        for (int k = 0; k < 2 * 11 + 5; k++) do_read();
        drain_check();

        // Truncation past capacity: R9
        start_scan(1'b0);
        write_all(14, 1'b0, 10'h3F0);
        for (int k = 0; k < 2 * 12 + 4; k++) do_read();
        drain_check();

        // Completed scan with nothing stored: R11
        start_scan(1'b1);
        wr_valid = 1; wr_chan = CH_W'(REFC); wr_data = 10'h155; wr_last = 1;
        @(negedge clk);
        wr_valid = 0; wr_last = 0;
        chk(scan_done == 1'b1, "R7 done on excluded last", scan_done, 1);
        mready = 1;
        @(negedge clk);
        do_read();
        do_read();
        drain_check();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule